// File: doc/BRIEF.md
# Dual-output steerable interrupt controller

The block collects up to 32 peripheral interrupt lines and presents them to a CPU on two request outputs. Each source has its own trigger code, which selects level sensing, edge sensing or off. Each source also has a steering bit, a source-enable bit, a mask bit and a wakeup-enable bit. Software addresses a source as one bit of a 32-bit word. Every control field is changed through a pair of write ports, one that sets bits and one that clears them, so no read-modify-write is needed. The field reads back at its own address.

Source inputs are first synchronised by two flops. Edge events are then held in a per-source pending latch. Software releases that latch by clearing the source's mask bit and then setting it again, which is the normal acknowledge sequence after service. Level sources are never latched and follow the synchronised input. Two read-only status words show, for each request output, the active, enabled and unmasked sources steered to it. A separate wakeup output reports any active, enabled source whose wakeup bit is set.

Top module: `irq_steer_ctrl`

## Requirements
- R1: Seven 32-bit control fields read back unchanged. Control field k (0 = trig bit 0, 1 = trig bit 1, 2 = trig bit 2, 3 = steer, 4 = source enable, 5 = mask, 6 = wakeup enable) is set at write address 2k and cleared at write address 2k+1, and reads at read address 2k.
- R2: A write to a set address turns on every bit that is 1 in the data. A write to a clear address turns off every such bit. Bits written as 0 keep their value.
- R3: The trigger code is {trig bit 2, trig bit 1, trig bit 0}. Code 101 makes a source active while its synchronised input is high. Code 100 makes it active while the input is low.
- R4: Code 001 latches a rising edge and code 010 latches a falling edge. Code 011 latches either edge. A latched edge stays active after the input returns.
- R5: Codes 000, 110 and 111 make a source inactive. Moving a source to any code that is not an edge code drops its latched edge.
- R6: A source whose steer bit is 1 appears in status word 0 (read address 14) and drives request output 0. A source whose steer bit is 0 appears in status word 1 (read address 15) and drives request output 1.
- R7: A source appears in a status word only when both its source-enable bit and its mask bit are 1.
- R8: Writing 1 to a source's bit at the mask clear address clears its latched edge. After the mask bit is set again, the source stays quiet until a new edge arrives.
- R9: Each request output is a register holding the OR of its status word. It rises one cycle after that status word becomes non-zero.
- R10: The wakeup output rises one cycle after any source is active with both its source-enable and wakeup-enable bits set. The mask bit and the steer bit do not affect it.
- R11: After reset, all control fields, both status words, both request outputs and the wakeup output are zero.
- R12: A change on a level-sensed input reaches the status word two clock edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 4 | Write address (set/clear port select) |
| wr_data_i | input | 32 | Write data, one bit per source |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 32 | Read data (combinational) |
| src_i | input | 32 | Asynchronous source lines |
| req_o | output | 2 | Request outputs 0 and 1 |
| wake_o | output | 1 | Wakeup request |

## Verification
On every cycle the assertions check the following:
- the set and clear semantics of each control field;
- that an acknowledge always empties a pending latch, and that a latched edge holds until it is acknowledged;
- that off codes never produce an active source;
- that a raised request or wakeup output always had an enabled, unmasked, correctly steered or wake-enabled source behind it one cycle earlier.

The bench scenarios cover the behaviour that depends on timing and on input patterns. These are the two-edge synchroniser latency, the one-cycle request delay, edge polarity selection, the persistence of a latched edge after the input falls back, and the effect of the mask-clear acknowledge. They also compare read-back and status words under random sequences of writes and input changes.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int NSRC   = 32;
  localparam int NREG   = 7;
  localparam int AW     = 4;
  localparam int REG_T0 = 0;
  localparam int REG_T1 = 1;
  localparam int REG_T2 = 2;
  localparam int REG_ST = 3;
  localparam int REG_EN = 4;
  localparam int REG_MK = 5;
  localparam int REG_WK = 6;

  localparam logic [2:0] TRG_OFF  = 3'b000;
  localparam logic [2:0] TRG_RISE = 3'b001;
  localparam logic [2:0] TRG_FALL = 3'b010;
  localparam logic [2:0] TRG_BOTH = 3'b011;
  localparam logic [2:0] TRG_LOW  = 3'b100;
  localparam logic [2:0] TRG_HIGH = 3'b101;
endpackage

// File: rtl/setclr_reg.sv
module setclr_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (set_i) q_o <= q_o | data_i;
    else if (clr_i) q_o <= q_o & ~data_i;
  end

  AST_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((q_o & $past(data_i)) == $past(data_i))); // R2
  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> ((q_o & $past(data_i)) == '0)); // R2
  AST_ZERO_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i || clr_i) |=> ((q_o & ~$past(data_i)) == ($past(q_o) & ~$past(data_i)))); // R2
endmodule

// File: rtl/src_detect.sv
module src_detect
  import irq_steer_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] trg0_i,
  input  logic [N-1:0] trg1_i,
  input  logic [N-1:0] trg2_i,
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] active_o
);
  logic [N-1:0] sync1_q, sync2_q, prev_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= src_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    logic [2:0] code;
    logic       rise, fall, is_edge, hit;
    assign code    = {trg2_i[i], trg1_i[i], trg0_i[i]};
    assign rise    = sync2_q[i] & ~prev_q[i];
    assign fall    = ~sync2_q[i] & prev_q[i];
    assign is_edge = (code == TRG_RISE) || (code == TRG_FALL) || (code == TRG_BOTH);
    assign hit     = ((code == TRG_RISE) && rise) || ((code == TRG_FALL) && fall) ||
                     ((code == TRG_BOTH) && (rise || fall));

    // acknowledge wins over a same-cycle edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   pend_q[i] <= 1'b0;
      else if (ack_i[i] || !is_edge) pend_q[i] <= 1'b0;
      else if (hit)                  pend_q[i] <= 1'b1;
    end

    always_comb begin
      unique case (code)
        TRG_HIGH: active_o[i] = sync2_q[i];
        TRG_LOW:  active_o[i] = ~sync2_q[i];
        TRG_RISE, TRG_FALL, TRG_BOTH: active_o[i] = pend_q[i];
        default:  active_o[i] = 1'b0;
      endcase
    end

    AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((code == TRG_OFF) || (code[2:1] == 2'b11)) |-> !active_o[i]); // R5
    AST_ACK_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_i[i] |=> !pend_q[i]); // R8
    AST_PEND_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q[i] && !ack_i[i] && is_edge) |=> pend_q[i]); // R4
  end
endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
  import irq_steer_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [NSRC-1:0] wr_data_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic [NSRC-1:0] rd_data_o,
  input  logic [NSRC-1:0] src_i,
  output logic [1:0]      req_o,
  output logic            wake_o
);
  logic [NREG-1:0][NSRC-1:0] ctl;
  logic [NSRC-1:0] active, stat0, stat1, ack, live;

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic sel;
    assign sel = wr_en_i && (wr_addr_i[AW-1:1] == (AW-1)'(k));
    setclr_reg #(.W(NSRC)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (sel && !wr_addr_i[0]),
      .clr_i  (sel && wr_addr_i[0]),
      .data_i (wr_data_i),
      .q_o    (ctl[k])
    );
  end

  assign ack = (wr_en_i && wr_addr_i == AW'(2*REG_MK + 1)) ? wr_data_i : '0;

  src_detect #(.N(NSRC)) u_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src_i),
    .trg0_i   (ctl[REG_T0]),
    .trg1_i   (ctl[REG_T1]),
    .trg2_i   (ctl[REG_T2]),
    .ack_i    (ack),
    .active_o (active)
  );

  assign live  = active & ctl[REG_EN];
  assign stat0 = live & ctl[REG_MK] & ctl[REG_ST];
  assign stat1 = live & ctl[REG_MK] & ~ctl[REG_ST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o  <= '0;
      wake_o <= 1'b0;
    end else begin
      req_o  <= {|stat1, |stat0};
      wake_o <= |(live & ctl[REG_WK]);
    end
  end

  always_comb begin
    if (rd_addr_i[AW-1:1] < (AW-1)'(NREG)) rd_data_o = ctl[rd_addr_i[AW-1:1]];
    else if (rd_addr_i[0])                 rd_data_o = stat1;
    else                                   rd_data_o = stat0;
  end

  AST_REQ0_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o[0] |-> ($past(ctl[REG_EN] & ctl[REG_MK] & ctl[REG_ST]) != '0)); // R6
  AST_REQ1_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o[1] |-> ($past(ctl[REG_EN] & ctl[REG_MK] & ~ctl[REG_ST]) != '0)); // R7
  AST_WAKE_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> ($past(ctl[REG_EN] & ctl[REG_WK]) != '0)); // R10
endmodule

// File: tb/irq_steer_ctrl_bench.sv
module irq_steer_ctrl_bench;
  import irq_steer_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data, src = '0;
  logic [1:0] req;
  logic wake;
  int checks = 0, errors = 0;

  logic [31:0] m [7];
  logic [31:0] pend = '0;

  always #10 clk = ~clk;

  irq_steer_ctrl u_irq_steer_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .src_i(src), .req_o(req), .wake_o(wake)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] code_of(int i);
    return {m[2][i], m[1][i], m[0][i]};
  endfunction

  function automatic logic [31:0] edge_mask();
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) r[i] = (code_of(i) inside {TRG_RISE, TRG_FALL, TRG_BOTH});
    return r;
  endfunction

  function automatic logic [31:0] exp_active();
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) begin
      case (code_of(i))
        TRG_HIGH: r[i] = src[i];
        TRG_LOW:  r[i] = ~src[i];
        TRG_RISE, TRG_FALL, TRG_BOTH: r[i] = pend[i];
        default:  r[i] = 1'b0;
      endcase
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_stat(bit out1);
    logic [31:0] q = exp_active() & m[REG_EN] & m[REG_MK];
    return out1 ? (q & ~m[REG_ST]) : (q & m[REG_ST]);
  endfunction

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 14) begin
      if (a[0]) m[a >> 1] &= ~d;
      else      m[a >> 1] |= d;
      if (a == 4'(2*REG_MK + 1)) pend &= ~d;
    end
    pend &= edge_mask();
    repeat (3) @(negedge clk);
  endtask

  task automatic drive_src(logic [31:0] nv);
    for (int i = 0; i < 32; i++) begin
      logic r = ~src[i] & nv[i];
      logic f = src[i] & ~nv[i];
      case (code_of(i))
        TRG_RISE: if (r) pend[i] = 1'b1;
        TRG_FALL: if (f) pend[i] = 1'b1;
        TRG_BOTH: if (r | f) pend[i] = 1'b1;
        default: ;
      endcase
    end
    @(negedge clk);
    src = nv;
    repeat (5) @(negedge clk);
  endtask

  task automatic check_all(string tag);
    logic [31:0] d;
    logic [31:0] s0, s1;
    for (int k = 0; k < 7; k++) begin
      rd(4'(2*k), d);
      chk({tag, " R1 readback"}, d, m[k]);
    end
    s0 = exp_stat(1'b0);
    s1 = exp_stat(1'b1);
    rd(4'd14, d); chk({tag, " R6 status0"}, d, s0);
    rd(4'd15, d); chk({tag, " R6 status1"}, d, s1);
    chk({tag, " R9 req"}, {30'd0, req}, {30'd0, |s1, |s0});
    chk({tag, " R10 wake"}, {31'd0, wake},
        {31'd0, |(exp_active() & m[REG_EN] & m[REG_WK])});
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed));
    for (int k = 0; k < 7; k++) m[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R11 reset");

    // R2: set/clear leave zero bits alone
    wr(4'd2*REG_WK, 32'hF0F0_00FF);
    wr(4'd2*REG_WK + 1, 32'h0000_000F);
    rd(4'd2*REG_WK, d); chk("R2 set/clear", d, 32'hF0F0_00F0);

    // R12/R9: level-high latency on source 3 steered to out0
    wr(4'd2*REG_T0, 32'h8);
    wr(4'd2*REG_T2, 32'h8);
    wr(4'd2*REG_EN, 32'h8);
    wr(4'd2*REG_MK, 32'h8);
    wr(4'd2*REG_ST, 32'h8);
    check_all("R3 level idle");
    @(negedge clk); src[3] = 1'b1;
    @(negedge clk); rd(4'd14, d); chk("R12 one edge", d, 32'h0);
    @(negedge clk); rd(4'd14, d); chk("R12 two edges", d, 32'h8);
    chk("R9 req lags", {31'd0, req[0]}, 32'h0);
    @(negedge clk); chk("R9 req rises", {31'd0, req[0]}, 32'h1);
    check_all("R3 level high");

    // R3: active-low
    wr(4'd2*REG_T0 + 1, 32'h8);
    check_all("R3 level low");
    drive_src(src & ~32'h8);
    check_all("R3 low active");

    // R4/R8: rising edge on source 7 to out1
    wr(4'd2*REG_T0, 32'h80);
    wr(4'd2*REG_EN, 32'h80);
    wr(4'd2*REG_MK, 32'h80);
    wr(4'd2*REG_WK, 32'h80);
    drive_src(src | 32'h80);
    rd(4'd15, d); chk("R4 rise latched", d & 32'h80, 32'h80);
    chk("R10 wake edge", {31'd0, wake}, 32'h1);
    drive_src(src & ~32'h80);
    rd(4'd15, d); chk("R4 latch holds", d & 32'h80, 32'h80);
    wr(4'd2*REG_MK + 1, 32'h80);
    wr(4'd2*REG_MK, 32'h80);
    rd(4'd15, d); chk("R8 ack clears", d & 32'h80, 32'h0);
    check_all("R8 after ack");

    // R7: enable required
    drive_src(src | 32'h80);
    wr(4'd2*REG_EN + 1, 32'h80);
    rd(4'd15, d); chk("R7 enable off", d & 32'h80, 32'h0);
    wr(4'd2*REG_EN, 32'h80);
    rd(4'd15, d); chk("R7 enable on", d & 32'h80, 32'h80);

    // R5: off code drops latch
    wr(4'd2*REG_T0 + 1, 32'h80);
    wr(4'd2*REG_T0, 32'h80);
    rd(4'd15, d); chk("R5 off drops", d & 32'h80, 32'h0);

    // random mix
    for (int it = 0; it < 120; it++) begin
      int sel = $urandom_range(0, 9);
      if (sel < 6) wr(4'($urandom_range(0, 13)), $urandom);
      else drive_src($urandom);
      check_all("rand R4 R5");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule